// File: doc/BRIEF.md
# Completion Descriptor Ring Producer

This block turns a stream of finished requests into 64-bit completion descriptors and places them, one after another, into a circular ring of slots held in local storage. Each descriptor names the request that finished and says whether it completed cleanly or left a reply frame behind. Software consumes descriptors from the same ring. It marks each consumed slot as free again by overwriting it with all ones, and it reports its read position through an index register.

The producer writes only slots that the host index marks as free. It refuses to write a slot that does not hold the empty pattern and raises a sticky overrun flag instead. While any descriptor is unconsumed it shows a pending status, and it drives an interrupt that a mask bit can block. A ring of DEPTH slots holds at most DEPTH-1 outstanding descriptors. The completion input stalls when one more push would make the producer index equal the host index.

Top module: `rpost_ring`

## Requirements
- R1: After reset the producer and host indices are 0, every slot reads all ones, the interrupt is masked, status_pend, irq and ovr_err are 0, and cpl_ready is 1.
- R2: An accepted completion with a non-zero SMID that finds its slot empty stores word 0 = {SMID in bits 31:16, zeros in bits 15:1, reply type in bit 0}, where type 1 means an address reply and 0 a successful I/O. It stores word 1 = the frame address for an address reply and 0 otherwise. host_rd_data carries word 0 in bits 31:0 and word 1 in bits 63:32.
- R3: Each stored descriptor advances prod_idx by one, and the index wraps from DEPTH-1 to 0.
- R4: cpl_ready is 0 exactly when the successor of prod_idx equals the host index. While it is 0, an offered completion changes no slot and no index.
- R5: When an accepted completion finds its slot not all ones, ovr_err becomes 1 and stays 1 until reset. The slot and prod_idx are left unchanged.
- R6: A completion with SMID 0 is consumed with no slot write, no index change and no overrun.
- R7: A register write to offset 0x6C with a value below DEPTH sets the host index for the next cycle. Larger values are ignored.
- R8: status_pend is 1 exactly when prod_idx differs from the host index.
- R9: A register write to offset 0x34 loads the mask from data bit 3 (1 = masked). irq equals status_pend AND NOT mask. Writes to any other offset change nothing.
- R10: A host slot write replaces both words of the addressed slot. A producer store to the same slot in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpl_valid | input | 1 | Completion offered |
| cpl_ready | output | 1 | Completion can be taken this cycle |
| cpl_smid | input | 16 | Identifier of the finished request |
| cpl_is_addr | input | 1 | 1 = address reply, 0 = successful I/O |
| cpl_addr | input | 32 | Reply frame address |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| host_wr | input | 1 | Host slot write strobe |
| host_wr_slot | input | IDX_W | Slot written by the host |
| host_wr_data | input | 64 | Both words of the host slot write |
| host_rd_slot | input | IDX_W | Slot read by the host |
| host_rd_data | output | 64 | Contents of the read slot (all ones if out of range) |
| prod_idx | output | IDX_W | Next slot the producer will fill |
| status_pend | output | 1 | Descriptors pending |
| irq | output | 1 | Masked reply interrupt |
| ovr_err | output | 1 | Sticky overrun flag |

## Verification
The bench runs several laps around a six-slot ring, which is not a power of two. This catches an index that wraps at a power of two instead of at DEPTH-1, because such an index would fill a phantom slot or skip slot 0. It fills the ring until cpl_ready falls. A design that counts full one slot late would overwrite the oldest unconsumed descriptor.

The bench also covers several cases that a wrong design would get visibly wrong:
- A slot left dirty by the host must raise the sticky overrun flag and leave the slot untouched. A design without the empty check would silently clobber data.
- A descriptor with SMID 0 must not be stored; a design that stores it would advance the index.
- Out-of-range host index writes and writes to unrelated offsets must be ignored; honouring them would corrupt the full test.
- The mask must be toggled while descriptors are pending; an inverted mask polarity would show at irq.

// File: rtl/rpost_ring.sv
module rpost_ring #(
  parameter int DEPTH = 6,
  parameter logic [7:0] IDX_OFS = 8'h6C,
  parameter logic [7:0] MASK_OFS = 8'h34,
  localparam int IDX_W = (DEPTH > 2) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpl_valid,
  output logic             cpl_ready,
  input  logic [15:0]      cpl_smid,
  input  logic             cpl_is_addr,
  input  logic [31:0]      cpl_addr,
  input  logic             reg_wr,
  input  logic [7:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  input  logic             host_wr,
  input  logic [IDX_W-1:0] host_wr_slot,
  input  logic [63:0]      host_wr_data,
  input  logic [IDX_W-1:0] host_rd_slot,
  output logic [63:0]      host_rd_data,
  output logic [IDX_W-1:0] prod_idx,
  output logic             status_pend,
  output logic             irq,
  output logic             ovr_err
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);
  localparam logic [63:0] EMPTY = '1;

  logic [63:0]      ring [DEPTH];
  logic [IDX_W-1:0] prod_q, host_q, prod_nxt;
  logic             mask_q, ovr_q;
  logic             take, slot_empty, store, clash;
  logic [63:0]      desc;

  assign prod_nxt   = (prod_q == LAST) ? '0 : prod_q + 1'b1;
  assign cpl_ready  = (prod_nxt != host_q);
  assign take       = cpl_valid && cpl_ready && (cpl_smid != 16'h0);
  assign slot_empty = (ring[prod_q] == EMPTY);
  assign store      = take && slot_empty;
  assign clash      = take && !slot_empty;
  assign desc       = {cpl_is_addr ? cpl_addr : 32'h0, cpl_smid, 15'h0, cpl_is_addr};

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    localparam logic [IDX_W-1:0] ME = IDX_W'(g);
    always_ff @(posedge clk) begin
      if (!rst_n)                            ring[g] <= EMPTY;
      else if (store && prod_q == ME)        ring[g] <= desc;
      else if (host_wr && host_wr_slot == ME) ring[g] <= host_wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prod_q <= '0;
      host_q <= '0;
      mask_q <= 1'b1;
      ovr_q  <= 1'b0;
    end else begin
      if (store) prod_q <= prod_nxt;
      if (clash) ovr_q <= 1'b1;
      if (reg_wr && reg_addr == IDX_OFS && reg_wdata <= 32'(DEPTH - 1))
        host_q <= reg_wdata[IDX_W-1:0];
      if (reg_wr && reg_addr == MASK_OFS)
        mask_q <= reg_wdata[3];
    end
  end

  assign host_rd_data = (host_rd_slot <= LAST) ? ring[host_rd_slot] : EMPTY;
  assign prod_idx     = prod_q;
  assign status_pend  = (prod_q != host_q);
  assign irq          = status_pend && !mask_q;
  assign ovr_err      = ovr_q;
endmodule

// File: rtl/rpost_ring_chk.sv
module rpost_ring_chk #(
  parameter int DEPTH = 6,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpl_valid,
  input logic             cpl_ready,
  input logic [15:0]      cpl_smid,
  input logic             reg_wr,
  input logic [IDX_W-1:0] prod_idx,
  input logic             status_pend,
  input logic             irq,
  input logic             ovr_err
);
  a_r3_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    prod_idx <= IDX_W'(DEPTH - 1));

  a_r4_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !cpl_ready) |=> $stable(prod_idx));

  a_r5_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_err |=> ovr_err);

  a_r5_ovr_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_err) |-> $stable(prod_idx));

  a_r6_smid0_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && cpl_smid == 16'h0) |=> $stable(prod_idx));

  a_r8_pend_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_pend) |-> $past(cpl_valid && cpl_ready) || $past(reg_wr));

  a_r9_irq_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> status_pend);
endmodule

bind rpost_ring rpost_ring_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
  .cpl_smid(cpl_smid), .reg_wr(reg_wr), .prod_idx(prod_idx),
  .status_pend(status_pend), .irq(irq), .ovr_err(ovr_err));

// File: tb/sim_rpost_ring.sv
module sim_rpost_ring;
  localparam int CLK_P = 10;
  localparam int D = 6;
  localparam int IW = 3;
  localparam logic [63:0] ONES = '1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpl_valid = 0, cpl_is_addr = 0, reg_wr = 0, host_wr = 0;
  logic [15:0] cpl_smid = 0;
  logic [31:0] cpl_addr = 0, reg_wdata = 0;
  logic [7:0] reg_addr = 0;
  logic [IW-1:0] host_wr_slot = 0, host_rd_slot = 0;
  logic [63:0] host_wr_data = 0;
  logic cpl_ready, status_pend, irq, ovr_err;
  logic [63:0] host_rd_data;
  logic [IW-1:0] prod_idx;

  int checks = 0, fails = 0;
  logic [63:0] em [D];
  int ep = 0, eh = 0;
  logic emask = 1, eovr = 0;

  always #(CLK_P/2) clk = ~clk;

  rpost_ring #(.DEPTH(D)) u0 (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk); #2;
  endtask

  task automatic verify_all;
    for (int i = 0; i < D; i++) begin
      host_rd_slot = IW'(i); #1;
      chk("R2/R10 slot", host_rd_data, em[i]);
    end
    chk("R3 prod_idx", 64'(prod_idx), 64'(ep));
    chk("R8 status_pend", 64'(status_pend), 64'(ep != eh));
    chk("R9 irq", 64'(irq), 64'((ep != eh) && !emask));
    chk("R5 ovr_err", 64'(ovr_err), 64'(eovr));
  endtask

  task automatic push(input logic [15:0] smid, input logic isa, input logic [31:0] a);
    bit rdy;
    rdy = (((ep + 1) % D) != eh);
    cpl_valid = 1; cpl_smid = smid; cpl_is_addr = isa; cpl_addr = a; #1;
    chk("R4 cpl_ready", 64'(cpl_ready), 64'(rdy));
    if (rdy && smid != 0) begin
      if (em[ep] == ONES) begin
        em[ep] = {isa ? a : 32'h0, smid, 15'h0, isa};
        ep = (ep + 1) % D;
      end else eovr = 1;
    end
    step;
    cpl_valid = 0;
  endtask

  task automatic regw(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    if (a == 8'h6C && d < D) eh = int'(d);
    if (a == 8'h34) emask = d[3];
    step;
    reg_wr = 0;
  endtask

  task automatic hostw(input int s, input logic [63:0] d);
    host_wr = 1; host_wr_slot = IW'(s); host_wr_data = d;
    em[s] = d;
    step;
    host_wr = 0;
  endtask

  task automatic consume(input int n);
    for (int k = 0; k < n; k++) begin
      hostw(eh, ONES);
      regw(8'h6C, 32'((eh + 1) % D));
    end
  endtask

  initial begin
    for (int i = 0; i < D; i++) em[i] = ONES;
    repeat (3) step;
    rst_n = 1; #1;
    // R1 reset state
    chk("R1 cpl_ready", 64'(cpl_ready), 64'(1));
    verify_all;
    regw(8'h34, 32'h0);
    verify_all;
    // R2/R3/R4 laps around the ring
    for (int lap = 0; lap < 4; lap++) begin
      for (int k = 0; k < D; k++)
        push(16'(lap * 16 + k + 1), 1'(k % 2), 32'hA000_0000 + 32'(lap * 256 + k * 4));
      verify_all;
      consume(lap == 3 ? 5 : 3 + lap % 2);
      verify_all;
    end
    // R6 SMID 0 discarded
    push(16'h0, 1'b1, 32'hDEAD_0000);
    verify_all;
    push(16'hFFFF, 1'b0, 32'h1234_5678);
    verify_all;
    // R7 out-of-range host index ignored
    regw(8'h6C, 32'(D));
    regw(8'h6C, 32'h7);
    regw(8'h6C, 32'h100);
    verify_all;
    // R9 mask and foreign offsets
    regw(8'h34, 32'h8);
    verify_all;
    regw(8'h30, 32'h0);
    verify_all;
    regw(8'h34, 32'hFFFF_FFF7);
    verify_all;
    consume(1);
    verify_all;
    // R10 host write, then R5 overrun on the dirty slot
    hostw((ep + 2) % D, 64'h0123_4567_89AB_CDEF);
    hostw(ep, 64'hFFFF_FFFF_0000_0000);
    verify_all;
    push(16'h0042, 1'b1, 32'hB000_0000);
    verify_all;
    hostw(ep, ONES);
    push(16'h0043, 1'b0, 32'h0);
    verify_all;
    push(16'h0044, 1'b1, 32'hC000_0010);
    verify_all;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule